// File: doc/BRIEF.md
# Mode-Configurable SPI Master Shifter

This block moves one byte at a time as the master of a four-wire serial link. It drives the serial clock, the outgoing data line and an active-low slave select, and it captures the incoming data line. Before each transfer the host chooses the clock polarity, the clock phase, the bit order and the clock divider. The mode number is polarity×2 + phase, so all four transfer modes are covered. Either end of the byte can go first.

The host places a byte on `tx_byte` together with the settings and pulses `start` for one clock. The block raises `busy` and pulls `cs_n` low. It then produces sixteen serial clock edges, each one half period apart, and releases `cs_n` half a period after the last edge. In that same cycle it raises a single-cycle `done` and updates `rx_byte`. One serial clock half period equals `half_div + 1` system clocks.

Top module: `spi_byte_master`

## Requirements
- R1: While no transfer runs, `cs_n` is 1, `busy` is 0, `mosi` is 0, `done` is 0, and `sck` equals the value `cpol` had one system clock earlier. So the resting level is low for polarity 0 and high for polarity 1.
- R2: A `start` seen while idle is accepted on that clock edge. From that edge `cs_n` is 0 and `busy` is 1. The polarity, phase, order, divider and transmit byte are captured on the same edge.
- R3: A serial clock half period lasts `half_div + 1` system clocks. The first `sck` edge comes one half period after `cs_n` falls. Exactly 16 `sck` edges occur, and `cs_n` rises one half period after the 16th edge.
- R4: With phase 0 (modes 0 and 2), the first data bit is on `mosi` as soon as `cs_n` is low. `miso` is sampled on leading edges: rising for polarity 0, falling for polarity 1. The next bit is set up on trailing edges.
- R5: With phase 1 (modes 1 and 3), `mosi` stays 0 until the first leading edge, and that edge drives the first bit. Later bits are set up on leading edges, and `miso` is sampled on trailing edges.
- R6: With `lsb_first` at 0, bits go out as bit 7 first down to bit 0. With `lsb_first` at 1, bits go out as bit 0 first up to bit 7. Received bits are placed using the same order.
- R7: `done` is high for exactly one system clock. It rises on the same edge where `busy` falls and `rx_byte` takes the received byte. `rx_byte` changes at no other time and is 0 after reset.
- R8: A `start` that arrives during a transfer is ignored. Changes to `cpol`, `cpha`, `lsb_first`, `half_div` or `tx_byte` during a transfer leave its waveform and result unchanged.
- R9: During a transfer, `mosi` changes only on system clock edges where `sck` also toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a transfer |
| cpol | input | 1 | Clock polarity (idle level of `sck`) |
| cpha | input | 1 | Clock phase: 0 samples on leading edges, 1 on trailing edges |
| lsb_first | input | 1 | Bit order: 0 sends MSB first, 1 sends LSB first |
| half_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| tx_byte | input | DATA_W | Byte to send |
| rx_byte | output | DATA_W | Last byte received |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low slave select |

## Verification
The bench targets several corner cases:
- Each of the four modes with both bit orders. A design that swapped sample and setup edges would capture a byte shifted by one bit.
- A divider of zero, where every system clock is an `sck` edge. An off-by-one in the half-period counter would stretch or drop edges.
- Settings and the transmit byte toggled mid-transfer, together with an extra `start`. A design that reads live inputs instead of captured ones would change `sck`, `mosi` or the result.
- Phase 1 with `mosi` held low before the first edge, and the exact cycles where `cs_n` moves. A wrong count would add a seventeenth edge or release the select early.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } spi_mode_t;
endpackage

// File: rtl/spi_tick_gen.sv
// Half-period timer: pulses tick every (half_len + 1) clocks while run is high.
module spi_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == half_len);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_seq.sv
// Transfer sequencer: select, serial clock, edge bookkeeping and strobes.
module spi_seq
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      tick,
  input  logic      cpol_live,
  input  spi_mode_t mode,
  output logic      load,
  output logic      busy,
  output logic      cs_n,
  output logic      sck,
  output logic      done,
  output logic      sample_en,
  output logic      shift_en,
  output logic      finish,
  output logic      lead_wait
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CW    = $clog2(EDGES + 2);
  localparam logic [CW-1:0] LAST_EDGE = CW'(EDGES);
  localparam logic [CW-1:0] SH0_MAX   = CW'(EDGES - 3);
  localparam logic [CW-1:0] SH1_MAX   = CW'(EDGES - 2);
  localparam logic [CW-1:0] SH1_MIN   = CW'(2);

  logic [CW-1:0] edge_q, edge_d;
  logic busy_q, busy_d, cs_q, cs_d, sck_q, sck_d, done_q, done_d;
  logic step;

  assign load = start && !busy_q;
  assign step = busy_q && tick;

  always_comb begin
    busy_d = busy_q;
    cs_d   = cs_q;
    sck_d  = sck_q;
    edge_d = edge_q;
    done_d = 1'b0;
    if (!busy_q) begin
      sck_d = cpol_live;
      if (start) begin
        busy_d = 1'b1;
        cs_d   = 1'b0;
        edge_d = '0;
      end
    end else if (tick) begin
      edge_d = edge_q + 1'b1;
      if (edge_q < LAST_EDGE) begin
        sck_d = ~sck_q;
      end else begin
        busy_d = 1'b0;
        cs_d   = 1'b1;
        done_d = 1'b1;
      end
    end
  end

  always_comb begin
    // edge_q even: the coming edge is a leading one
    sample_en = step && (edge_q < LAST_EDGE) && (edge_q[0] == mode.cpha);
    if (!mode.cpha)
      shift_en = step && edge_q[0] && (edge_q <= SH0_MAX);
    else
      shift_en = step && !edge_q[0] && (edge_q >= SH1_MIN) && (edge_q <= SH1_MAX);
    finish    = step && (edge_q == LAST_EDGE);
    lead_wait = busy_q && (edge_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      edge_q <= '0;
    end else begin
      busy_q <= busy_d;
      cs_q   <= cs_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      edge_q <= edge_d;
    end
  end

  assign busy = busy_q;
  assign cs_n = cs_q;
  assign sck  = sck_q;
  assign done = done_q;
endmodule

// File: rtl/spi_shift_path.sv
// Data path: transmit bit pointer, receive shifter, result register.
module spi_shift_path
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_byte,
  input  spi_mode_t         mode,
  input  logic              busy,
  input  logic              lead_wait,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              finish,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int PW = $clog2(DATA_W);
  localparam logic [PW-1:0] TOP_IDX = PW'(DATA_W - 1);

  logic [DATA_W-1:0] tx_q, tx_d, sh_q, sh_d, rx_q, rx_d;
  logic [PW-1:0]     ptr_q, ptr_d, idx;

  always_comb begin
    tx_d  = tx_q;
    ptr_d = ptr_q;
    sh_d  = sh_q;
    rx_d  = rx_q;
    if (load) begin
      tx_d  = tx_byte;
      ptr_d = '0;
      sh_d  = '0;
    end else begin
      if (shift_en) ptr_d = ptr_q + 1'b1;
      if (sample_en) begin
        if (mode.lsb_first) sh_d = {miso, sh_q[DATA_W-1:1]};
        else                sh_d = {sh_q[DATA_W-2:0], miso};
      end
      if (finish) rx_d = sh_q;
    end
  end

  always_comb begin
    idx  = mode.lsb_first ? ptr_q : (TOP_IDX - ptr_q);
    mosi = (busy && !(mode.cpha && lead_wait)) ? tx_q[idx] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      ptr_q <= '0;
      sh_q  <= '0;
      rx_q  <= '0;
    end else begin
      tx_q  <= tx_d;
      ptr_q <= ptr_d;
      sh_q  <= sh_d;
      rx_q  <= rx_d;
    end
  end

  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  logic [1:0] rst_pipe;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  spi_mode_t        mode_q, mode_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic load, tick, sample_en, shift_en, finish, lead_wait;

  always_comb begin
    mode_d = mode_q;
    div_d  = div_q;
    if (load) begin
      mode_d = '{cpol: cpol, cpha: cpha, lsb_first: lsb_first};
      div_d  = half_div;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      mode_q <= '0;
      div_q  <= '0;
    end else begin
      mode_q <= mode_d;
      div_q  <= div_d;
    end
  end

  spi_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst_n(rst_n_sync), .run(busy), .half_len(div_q), .tick(tick)
  );

  spi_seq #(.DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n_sync), .start(start), .tick(tick),
    .cpol_live(cpol), .mode(mode_q), .load(load), .busy(busy),
    .cs_n(cs_n), .sck(sck), .done(done), .sample_en(sample_en),
    .shift_en(shift_en), .finish(finish), .lead_wait(lead_wait)
  );

  spi_shift_path #(.DATA_W(DATA_W)) path_i (
    .clk(clk), .rst_n(rst_n_sync), .load(load), .tx_byte(tx_byte),
    .mode(mode_q), .busy(busy), .lead_wait(lead_wait), .shift_en(shift_en),
    .sample_en(sample_en), .finish(finish), .miso(miso), .mosi(mosi),
    .rx_byte(rx_byte)
  );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpol,
  input logic              busy,
  input logic              done,
  input logic              sck,
  input logic              mosi,
  input logic              cs_n,
  input logic [DATA_W-1:0] rx_byte
);
  localparam int CNTW = $clog2(2 * DATA_W + 2);
  logic [1:0]      age;
  logic            ready;
  logic            sck_prev;
  logic [CNTW-1:0] edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age      <= 2'd0;
      sck_prev <= 1'b0;
      edges    <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      sck_prev <= sck;
      if (cs_n)                edges <= '0;
      else if (sck != sck_prev) edges <= edges + 1'b1;
    end
  end
  assign ready = (age == 2'd3);

  p_idle_sck_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !busy && $past(!busy)) |-> (sck == $past(cpol)));

  p_sixteen_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && done) |-> (edges == CNTW'(2 * DATA_W)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_with_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $fell(busy)) |-> done);

  p_rx_only_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !$stable(rx_byte)) |-> done);

  p_mosi_on_edges_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && busy && $past(busy) && $stable(sck)) |-> $stable(mosi));
endmodule

bind spi_byte_master spi_byte_master_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n_sync), .cpol(cpol), .busy(busy), .done(done),
  .sck(sck), .mosi(mosi), .cs_n(cs_n), .rx_byte(rx_byte)
);

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
module spi_byte_master_tb_top;
  logic       clk, rst_n, start, cpol, cpha, lsb_first, miso;
  logic [7:0] half_div, tx_byte, rx_byte;
  logic       busy, done, sck, mosi, cs_n;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_rx;
  bit finished = 0;

  spi_byte_master #(.DATA_W(8), .DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .half_div(half_div), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .busy(busy), .done(done), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit bit_at(input logic [7:0] b, input bit lsb, input int j);
    return lsb ? b[j] : b[7-j];
  endfunction

  // Line value after ed edges: the master's mosi and the slave's miso follow the same rule
  function automatic bit line_val(input logic [7:0] b, input bit pha, input bit lsb, input int ed);
    int j;
    if (ed >= 17) return 1'b0;
    if (!pha) j = ed / 2;
    else begin
      if (ed == 0) return 1'b0;   // R5: nothing driven before the first leading edge
      j = (ed - 1) / 2;
    end
    if (j > 7) j = 7;
    return bit_at(b, lsb, j);
  endfunction

  task automatic check_idle();
    // R1 idle levels, R7 result held
    chk(cs_n == 1'b1, "R1", "idle cs_n", cs_n, 1);
    chk(busy == 1'b0, "R1", "idle busy", busy, 0);
    chk(done == 1'b0, "R1", "idle done", done, 0);
    chk(mosi == 1'b0, "R1", "idle mosi", mosi, 0);
    chk(sck == cpol, "R1", "idle sck level", sck, cpol);
    chk(rx_byte == exp_rx, "R7", "rx held", rx_byte, exp_rx);
  endtask

  task automatic xfer(input bit pol, input bit pha, input bit lsb,
                      input logic [7:0] txb, input logic [7:0] slv,
                      input int hd, input bit disturb);
    int h = hd + 1;
    int total = 17 * h;
    @(negedge clk);
    cpol = pol; cpha = pha; lsb_first = lsb; half_div = 8'(hd); tx_byte = txb; miso = 0;
    @(negedge clk); check_idle();
    @(negedge clk); check_idle();
    start = 1;                      // R2: accepted at the next rising edge
    @(negedge clk);
    start = 0;
    for (int n = 0; n <= total; n++) begin
      int ed = n / h;
      if (ed > 17) ed = 17;
      if (n == total) begin
        // R3 select release and R7 completion, one half period after the 16th edge
        chk(cs_n == 1'b1, "R3", "cs_n rises", cs_n, 1);
        chk(busy == 1'b0, "R7", "busy falls with done", busy, 0);
        chk(done == 1'b1, "R7", "done pulse", done, 1);
        chk(mosi == 1'b0, "R1", "mosi after release", mosi, 0);
        chk(sck == pol, "R3", "sck back at rest", sck, pol);
        chk(rx_byte == slv, "R6", "received byte", rx_byte, slv);
        exp_rx = slv;
      end else begin
        chk(cs_n == 1'b0, "R2", "cs_n low during transfer", cs_n, 0);
        chk(busy == 1'b1, "R2", "busy during transfer", busy, 1);
        chk(done == 1'b0, "R7", "no early done", done, 0);
        chk(rx_byte == exp_rx, "R7", "rx stable during transfer", rx_byte, exp_rx);
        chk(sck == (pol ^ ed[0]), "R3", "sck edge timing", sck, pol ^ ed[0]);
        chk(mosi == line_val(txb, pha, lsb, ed), pha ? "R5" : "R4", "mosi bit",
            mosi, line_val(txb, pha, lsb, ed));
      end
      miso = line_val(slv, pha, lsb, ed);
      if (disturb && n == total / 2) begin
        // R8: extra start and changed settings mid-transfer
        start = 1; tx_byte = ~txb; cpol = ~pol; cpha = ~pha; lsb_first = ~lsb;
        half_div = 8'(hd + 3);
      end
      if (disturb && n == total / 2 + 1) start = 0;
      @(negedge clk);
    end
    start = 0;
    check_idle();
    chk(done == 1'b0, "R7", "done lasts one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; cpol = 0; cpha = 0; lsb_first = 0; miso = 0;
    half_div = 0; tx_byte = 0; exp_rx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_idle();                         // reset state, R1 and R7
    chk(rx_byte == 8'h00, "R7", "rx after reset", rx_byte, 0);

    xfer(0, 0, 0, 8'hA5, 8'h3C, 0, 0);    // mode 0, MSB first, fastest divider (R4, R6)
    xfer(0, 1, 1, 8'h81, 8'hC3, 1, 0);    // mode 1, LSB first (R5, R6)
    xfer(1, 0, 1, 8'h6E, 8'h17, 2, 0);    // mode 2, LSB first (R4)
    xfer(1, 1, 0, 8'hF0, 8'h0F, 0, 0);    // mode 3, MSB first (R5)
    xfer(0, 1, 0, 8'h3B, 8'hE2, 2, 0);    // mode 1, MSB first
    xfer(1, 0, 0, 8'hC9, 8'h5D, 1, 0);    // mode 2, MSB first
    xfer(0, 0, 1, 8'h2D, 8'hB4, 3, 1);    // R8 disturbance in mode 0
    xfer(1, 1, 1, 8'h55, 8'h9A, 1, 1);    // R8 disturbance in mode 3

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule